// File: doc/BRIEF.md
# Two-Port Hardware Semaphore Bank

This block holds a small bank of binary lock flags that two independent agents, a left port and a right port, use to claim shared resources from each other without any wait state. Each port selects one flag with a short index and writes a one-bit request. A 0 asks for the token and a 1 gives it back. Reading a flag returns a full data word. The word is all zeros when the reading side holds the token, and all ones otherwise.

Each flag keeps one request latch for each side and a record of which side currently holds it. A request that loses stays in its latch. When the holder lets go, the waiting side takes the token on the same clock edge with no further action. A read word is captured on the first cycle of a read access and held until that access ends, so a reader never sees the value change partway through.

Each port decodes its own chip-enable, semaphore-enable, read/write, output-enable and byte-select inputs. A combination that would address the main array and the flags at the same time is rejected and flagged. The block updates synchronously on one clock. A synchronous active-low reset makes every flag free.

Top module: `xsem_bank`

## Requirements
- R1: During and after synchronous reset (rst_n low at a clock edge), every flag is free, both read words are 16'h0000 and both error outputs are 0. A read of any flag from either side after reset returns 16'hFFFF.
- R2: A port makes a flag access when sel_n is 0 and either ce_n is 1 or both ub_n and lb_n are 1. With ce_n 1 and sel_n 0, wr_n 0 is a write and wr_n 1 with oe_n 0 is a read. A write with sel_n at 1 changes no flag.
- R3: A write affects only the flag named by idx. The value written is the single wbit input.
- R4: A request (wbit 0) to a free flag gives that side the token from the next edge. That side then reads 16'h0000 and the other side reads 16'hFFFF. The two sides never hold one flag at once.
- R5: A request from the side that does not hold a flag is stored and does not disturb the holder. A repeated request only refreshes the stored request.
- R6: When the holder writes 1, the flag goes to the other side at the same edge if that side has a stored request. Otherwise the flag becomes free.
- R7: If both sides request the same free flag in the same cycle, the left side gets the token.
- R8: A read returns the reading side's flag value (1 = not held by this side) copied into every bit. The value is captured at the edge that starts the read and stays frozen while the read remains active. The word is 16'h0000 whenever no read is active.
- R9: The combination ce_n 0, sel_n 0 and either byte select low is illegal. It changes no flag, and the port's err output is 1 for exactly the cycle after the edge that sampled it.
- R10: A side that is not the holder can withdraw its stored request by writing 1. A later release by the holder then leaves the flag free.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| l_ce_n | input | 1 | Left chip enable (active low, array select) |
| l_sel_n | input | 1 | Left semaphore enable (active low) |
| l_wr_n | input | 1 | Left write strobe (0 = write, 1 = read) |
| l_oe_n | input | 1 | Left output enable (active low) |
| l_ub_n | input | 1 | Left upper byte select (active low) |
| l_lb_n | input | 1 | Left lower byte select (active low) |
| l_idx | input | 3 | Left flag index |
| l_wbit | input | 1 | Left write value (0 = request, 1 = release) |
| l_rdat | output | 16 | Left read word |
| l_err | output | 1 | Left illegal-control pulse |
| r_ce_n | input | 1 | Right chip enable (active low, array select) |
| r_sel_n | input | 1 | Right semaphore enable (active low) |
| r_wr_n | input | 1 | Right write strobe (0 = write, 1 = read) |
| r_oe_n | input | 1 | Right output enable (active low) |
| r_ub_n | input | 1 | Right upper byte select (active low) |
| r_lb_n | input | 1 | Right lower byte select (active low) |
| r_idx | input | 3 | Right flag index |
| r_wbit | input | 1 | Right write value (0 = request, 1 = release) |
| r_rdat | output | 16 | Right read word |
| r_err | output | 1 | Right illegal-control pulse |

## Verification
The hardest case to reach is a hand-over that happens while the receiving side is in the middle of a read. A correct design keeps that side's word at the old value. To set this up, the left side first stores a request on a flag the right side holds. The left side then opens a read and keeps it open while the right side releases. The bench checks that the word stays frozen until the read is closed and opened again. Simultaneous requests on a free flag, and a release that meets a stored request, are produced by driving both ports in the same cycle. A reference model checks both read words and both error outputs on every clock.

// File: rtl/xsem_pkg.sv
package xsem_pkg;

    localparam int SEM_FLAGS  = 8;
    localparam int SEM_DATA_W = 16;

    typedef enum logic [1:0] {
        HOLD_NONE  = 2'd0,
        HOLD_LEFT  = 2'd1,
        HOLD_RIGHT = 2'd2
    } holder_e;

    // decoded intent of one port for the current cycle
    typedef struct packed {
        logic wr_go;   // flag write this cycle
        logic wr_val;  // value written (0 = request)
        logic rd_go;   // flag read active this cycle
        logic bad;     // illegal control combination
    } port_req_t;

    // per-flag state: two request latches (active low) and the holder
    typedef struct packed {
        logic    req_l;
        logic    req_r;
        holder_e holder;
    } flag_st_t;

    // read capture state of one port
    typedef struct packed {
        logic act;
        logic val;
    } rd_st_t;

    // registered error pulses
    typedef struct packed {
        logic err_l;
        logic err_r;
    } err_st_t;

endpackage

// File: rtl/xsem_port_dec.sv
module xsem_port_dec
    import xsem_pkg::*;
(
    input  logic      ce_n,
    input  logic      sel_n,
    input  logic      wr_n,
    input  logic      oe_n,
    input  logic      ub_n,
    input  logic      lb_n,
    input  logic      wbit,
    output port_req_t req
);

    logic sem_access;
    logic byte_on;

    always_comb begin
        byte_on    = !ub_n || !lb_n;
        // the flags are reachable with the array deselected, or with the
        // array enabled but no byte lane selected
        sem_access = !sel_n && (ce_n || !byte_on);
        req.wr_go  = sem_access && !wr_n;
        req.wr_val = wbit;
        req.rd_go  = sem_access && wr_n && !oe_n;
        req.bad    = !sel_n && !ce_n && byte_on;
    end

endmodule

// File: rtl/xsem_flag.sv
module xsem_flag
    import xsem_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic l_we,
    input  logic l_val,
    input  logic r_we,
    input  logic r_val,
    output logic l_own,
    output logic r_own
);

    flag_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (l_we) st_d.req_l = l_val;
        if (r_we) st_d.req_r = r_val;

        unique case (st_q.holder)
            HOLD_LEFT: begin
                if (st_d.req_l)
                    st_d.holder = st_d.req_r ? HOLD_NONE : HOLD_RIGHT;
            end
            HOLD_RIGHT: begin
                if (st_d.req_r)
                    st_d.holder = st_d.req_l ? HOLD_NONE : HOLD_LEFT;
            end
            default: begin
                // a same-cycle tie is settled toward the left side
                if (!st_d.req_l)      st_d.holder = HOLD_LEFT;
                else if (!st_d.req_r) st_d.holder = HOLD_RIGHT;
                else                  st_d.holder = HOLD_NONE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{req_l: 1'b1, req_r: 1'b1, holder: HOLD_NONE};
        end else begin
            st_q <= st_d;
        end
    end

    assign l_own = (st_q.holder == HOLD_LEFT);
    assign r_own = (st_q.holder == HOLD_RIGHT);

endmodule

// File: rtl/xsem_rd_hold.sv
module xsem_rd_hold
    import xsem_pkg::*;
#(
    parameter int NUM_FLAGS = SEM_FLAGS,
    parameter int DATA_W    = SEM_DATA_W,
    localparam int IDX_W    = $clog2(NUM_FLAGS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 rd_go,
    input  logic [IDX_W-1:0]     idx,
    input  logic [NUM_FLAGS-1:0] view,
    output logic [DATA_W-1:0]    rdat
);

    rd_st_t st_d, st_q;

    always_comb begin
        st_d.act = rd_go;
        st_d.val = st_q.val;
        // capture only on the first cycle of a read access
        if (rd_go && !st_q.act) st_d.val = view[idx];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{act: 1'b0, val: 1'b1};
        end else begin
            st_q <= st_d;
        end
    end

    assign rdat = st_q.act ? {DATA_W{st_q.val}} : '0;

endmodule

// File: rtl/xsem_bank.sv
module xsem_bank
    import xsem_pkg::*;
#(
    parameter int NUM_FLAGS = SEM_FLAGS,
    parameter int DATA_W    = SEM_DATA_W,
    localparam int IDX_W    = $clog2(NUM_FLAGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              l_ce_n,
    input  logic              l_sel_n,
    input  logic              l_wr_n,
    input  logic              l_oe_n,
    input  logic              l_ub_n,
    input  logic              l_lb_n,
    input  logic [IDX_W-1:0]  l_idx,
    input  logic              l_wbit,
    output logic [DATA_W-1:0] l_rdat,
    output logic              l_err,
    input  logic              r_ce_n,
    input  logic              r_sel_n,
    input  logic              r_wr_n,
    input  logic              r_oe_n,
    input  logic              r_ub_n,
    input  logic              r_lb_n,
    input  logic [IDX_W-1:0]  r_idx,
    input  logic              r_wbit,
    output logic [DATA_W-1:0] r_rdat,
    output logic              r_err
);

    port_req_t            l_req, r_req;
    logic [NUM_FLAGS-1:0] own_l, own_r;
    logic [NUM_FLAGS-1:0] view_l, view_r;
    err_st_t              err_d, err_q;

    xsem_port_dec u_dec_l (
        .ce_n (l_ce_n), .sel_n(l_sel_n), .wr_n(l_wr_n), .oe_n(l_oe_n),
        .ub_n (l_ub_n), .lb_n (l_lb_n),  .wbit(l_wbit), .req (l_req)
    );

    xsem_port_dec u_dec_r (
        .ce_n (r_ce_n), .sel_n(r_sel_n), .wr_n(r_wr_n), .oe_n(r_oe_n),
        .ub_n (r_ub_n), .lb_n (r_lb_n),  .wbit(r_wbit), .req (r_req)
    );

    for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_flag
        xsem_flag u_flag (
            .clk  (clk),
            .rst_n(rst_n),
            .l_we (l_req.wr_go && (l_idx == IDX_W'(g))),
            .l_val(l_req.wr_val),
            .r_we (r_req.wr_go && (r_idx == IDX_W'(g))),
            .r_val(r_req.wr_val),
            .l_own(own_l[g]),
            .r_own(own_r[g])
        );
    end

    // each side reads 0 only for flags it holds
    assign view_l = ~own_l;
    assign view_r = ~own_r;

    xsem_rd_hold #(.NUM_FLAGS(NUM_FLAGS), .DATA_W(DATA_W)) u_rd_l (
        .clk(clk), .rst_n(rst_n), .rd_go(l_req.rd_go), .idx(l_idx),
        .view(view_l), .rdat(l_rdat)
    );

    xsem_rd_hold #(.NUM_FLAGS(NUM_FLAGS), .DATA_W(DATA_W)) u_rd_r (
        .clk(clk), .rst_n(rst_n), .rd_go(r_req.rd_go), .idx(r_idx),
        .view(view_r), .rdat(r_rdat)
    );

    always_comb begin
        err_d.err_l = l_req.bad;
        err_d.err_r = r_req.bad;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_q <= '0;
        end else begin
            err_q <= err_d;
        end
    end

    assign l_err = err_q.err_l;
    assign r_err = err_q.err_r;

endmodule

// File: rtl/xsem_chk.sv
module xsem_chk
    import xsem_pkg::*;
#(
    parameter int NUM_FLAGS = SEM_FLAGS,
    parameter int DATA_W    = SEM_DATA_W,
    localparam int IDX_W    = $clog2(NUM_FLAGS)
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 l_ce_n,
    input logic                 l_sel_n,
    input logic                 l_wr_n,
    input logic                 l_ub_n,
    input logic                 l_lb_n,
    input logic [IDX_W-1:0]     l_idx,
    input logic [DATA_W-1:0]    l_rdat,
    input logic                 l_err,
    input logic                 r_ce_n,
    input logic                 r_sel_n,
    input logic                 r_ub_n,
    input logic                 r_lb_n,
    input logic [IDX_W-1:0]     r_idx,
    input logic [DATA_W-1:0]    r_rdat,
    input logic                 r_err,
    input port_req_t            l_req,
    input port_req_t            r_req,
    input logic [NUM_FLAGS-1:0] own_l,
    input logic [NUM_FLAGS-1:0] own_r
);

    // R2
    wr_decode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        l_req.wr_go |-> (!l_sel_n && !l_wr_n));

    // R4
    single_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (own_l & own_r) == '0);

    // R5
    holder_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (own_l[r_idx] && r_req.wr_go && !r_req.wr_val &&
         !(l_req.wr_go && l_req.wr_val && l_idx == r_idx))
        |=> own_l[$past(r_idx)]);

    // R6
    release_l_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (l_req.wr_go && l_req.wr_val && own_l[l_idx])
        |=> !own_l[$past(l_idx)]);

    // R7
    tie_left_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (l_req.wr_go && r_req.wr_go && !l_req.wr_val && !r_req.wr_val &&
         l_idx == r_idx && !own_l[l_idx] && !own_r[l_idx])
        |=> own_l[$past(l_idx)]);

    // R8
    word_form_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (l_rdat == '0 || l_rdat == '1) && (r_rdat == '0 || r_rdat == '1));

    // R8
    rd_hold_l_chk: assert property (@(posedge clk) disable iff (!rst_n)
        l_req.rd_go ##1 l_req.rd_go |=> $stable(l_rdat));

    // R8
    rd_hold_r_chk: assert property (@(posedge clk) disable iff (!rst_n)
        r_req.rd_go ##1 r_req.rd_go |=> $stable(r_rdat));

    // R9
    bad_l_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!l_sel_n && !l_ce_n && (!l_ub_n || !l_lb_n)) |=> l_err);

    // R9
    bad_r_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!r_sel_n && !r_ce_n && (!r_ub_n || !r_lb_n)) |=> r_err);

endmodule

bind xsem_bank xsem_chk #(.NUM_FLAGS(NUM_FLAGS), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/xsem_bank_tb.sv
module xsem_bank_tb;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        l_ce_n, l_sel_n, l_wr_n, l_oe_n, l_ub_n, l_lb_n, l_wbit;
    logic        r_ce_n, r_sel_n, r_wr_n, r_oe_n, r_ub_n, r_lb_n, r_wbit;
    logic [2:0]  l_idx, r_idx;
    logic [15:0] l_rdat, r_rdat;
    logic        l_err, r_err;

    int    n_checks = 0;
    int    n_errors = 0;
    string cur_tag  = "R1";
    bit    done     = 1'b0;

    // reference model state
    int m_own[8];      // 0 free, 1 left, 2 right
    bit m_rq_l[8];
    bit m_rq_r[8];
    bit m_act_l, m_val_l, m_act_r, m_val_r, m_err_l, m_err_r;

    always #(CLK_PERIOD/2) clk = ~clk;

    xsem_bank u_dut (
        .clk(clk), .rst_n(rst_n),
        .l_ce_n(l_ce_n), .l_sel_n(l_sel_n), .l_wr_n(l_wr_n), .l_oe_n(l_oe_n),
        .l_ub_n(l_ub_n), .l_lb_n(l_lb_n), .l_idx(l_idx), .l_wbit(l_wbit),
        .l_rdat(l_rdat), .l_err(l_err),
        .r_ce_n(r_ce_n), .r_sel_n(r_sel_n), .r_wr_n(r_wr_n), .r_oe_n(r_oe_n),
        .r_ub_n(r_ub_n), .r_lb_n(r_lb_n), .r_idx(r_idx), .r_wbit(r_wbit),
        .r_rdat(r_rdat), .r_err(r_err)
    );

    task automatic check(input string tag, input string what,
                         input logic [15:0] got, input logic [15:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_errors++;
            $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
        end
    endtask

    task automatic model_update();
        bit la, ra, lbad, rbad, lrd, rrd;
        if (!rst_n) begin
            for (int i = 0; i < 8; i++) begin
                m_own[i] = 0; m_rq_l[i] = 1; m_rq_r[i] = 1;
            end
            m_act_l = 0; m_val_l = 1; m_act_r = 0; m_val_r = 1;
            m_err_l = 0; m_err_r = 0;
            return;
        end
        la   = !l_sel_n && (l_ce_n || (l_ub_n && l_lb_n));
        ra   = !r_sel_n && (r_ce_n || (r_ub_n && r_lb_n));
        lbad = !l_sel_n && !l_ce_n && (!l_ub_n || !l_lb_n);
        rbad = !r_sel_n && !r_ce_n && (!r_ub_n || !r_lb_n);
        lrd  = la && l_wr_n && !l_oe_n;
        rrd  = ra && r_wr_n && !r_oe_n;
        if (lrd && !m_act_l) m_val_l = (m_own[l_idx] != 1);
        if (rrd && !m_act_r) m_val_r = (m_own[r_idx] != 2);
        m_act_l = lrd;
        m_act_r = rrd;
        if (la && !l_wr_n) m_rq_l[l_idx] = l_wbit;
        if (ra && !r_wr_n) m_rq_r[r_idx] = r_wbit;
        for (int i = 0; i < 8; i++) begin
            if (m_own[i] == 1 && m_rq_l[i])      m_own[i] = m_rq_r[i] ? 0 : 2;
            else if (m_own[i] == 2 && m_rq_r[i]) m_own[i] = m_rq_l[i] ? 0 : 1;
            else if (m_own[i] == 0)              m_own[i] = !m_rq_l[i] ? 1 : (!m_rq_r[i] ? 2 : 0);
        end
        m_err_l = lbad;
        m_err_r = rbad;
    endtask

    task automatic tick();
        @(posedge clk);
        model_update();
        @(negedge clk);
        check(cur_tag, "l_rdat", l_rdat, m_act_l ? {16{m_val_l}} : 16'h0);
        check(cur_tag, "r_rdat", r_rdat, m_act_r ? {16{m_val_r}} : 16'h0);
        check(cur_tag, "l_err", {15'h0, l_err}, {15'h0, m_err_l});
        check(cur_tag, "r_err", {15'h0, r_err}, {15'h0, m_err_r});
    endtask

    task automatic drv(input bit rgt, input logic sel_n, ce_n, wr_n, oe_n,
                       ub_n, lb_n, input logic [2:0] ix, input logic v);
        if (!rgt) begin
            l_sel_n = sel_n; l_ce_n = ce_n; l_wr_n = wr_n; l_oe_n = oe_n;
            l_ub_n = ub_n; l_lb_n = lb_n; l_idx = ix; l_wbit = v;
        end else begin
            r_sel_n = sel_n; r_ce_n = ce_n; r_wr_n = wr_n; r_oe_n = oe_n;
            r_ub_n = ub_n; r_lb_n = lb_n; r_idx = ix; r_wbit = v;
        end
    endtask

    task automatic quiet(input bit rgt);
        drv(rgt, 1, 1, 1, 1, 1, 1, 3'd0, 1'b1);
    endtask
    task automatic sem_wr(input bit rgt, input logic [2:0] ix, input logic v);
        drv(rgt, 0, 1, 0, 1, 1, 1, ix, v);
    endtask
    task automatic sem_rd(input bit rgt, input logic [2:0] ix);
        drv(rgt, 0, 1, 1, 0, 1, 1, ix, 1'b1);
    endtask
    task automatic both_quiet();
        quiet(0); quiet(1);
    endtask
    // read one flag from both sides in one cycle, then go quiet
    task automatic read_both(input logic [2:0] ix, input logic [15:0] exp_l,
                             input logic [15:0] exp_r, input string tag);
        cur_tag = tag;
        sem_rd(0, ix); sem_rd(1, ix); tick();
        check(tag, "direct l_rdat", l_rdat, exp_l);
        check(tag, "direct r_rdat", r_rdat, exp_r);
        both_quiet(); tick();
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            n_errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        both_quiet();
        rst_n = 1'b0;
        cur_tag = "R1";
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        check("R1", "reset l_rdat", l_rdat, 16'h0000);
        check("R1", "reset err", {14'h0, l_err, r_err}, 16'h0);
        for (int i = 0; i < 8; i++) read_both(3'(i), 16'hFFFF, 16'hFFFF, "R1");

        // R4: left claims free flag 3
        cur_tag = "R4";
        sem_wr(0, 3'd3, 1'b0); tick(); both_quiet(); tick();
        read_both(3'd3, 16'h0000, 16'hFFFF, "R4");
        // R3: neighbours untouched
        read_both(3'd2, 16'hFFFF, 16'hFFFF, "R3");
        read_both(3'd4, 16'hFFFF, 16'hFFFF, "R3");

        // R5: right requests flag 3, twice; left keeps it
        cur_tag = "R5";
        sem_wr(1, 3'd3, 1'b0); tick(); sem_wr(1, 3'd3, 1'b0); tick();
        both_quiet(); tick();
        read_both(3'd3, 16'h0000, 16'hFFFF, "R5");

        // R6: left releases, pending right takes over
        cur_tag = "R6";
        sem_wr(0, 3'd3, 1'b1); tick(); both_quiet(); tick();
        read_both(3'd3, 16'hFFFF, 16'h0000, "R6");
        cur_tag = "R6";
        sem_wr(1, 3'd3, 1'b1); tick(); both_quiet(); tick();
        read_both(3'd3, 16'hFFFF, 16'hFFFF, "R6");

        // R10: withdrawn request is not granted
        cur_tag = "R10";
        sem_wr(0, 3'd5, 1'b0); tick();
        quiet(0); sem_wr(1, 3'd5, 1'b0); tick();
        sem_wr(1, 3'd5, 1'b1); tick();
        quiet(1); sem_wr(0, 3'd5, 1'b1); tick();
        both_quiet(); tick();
        read_both(3'd5, 16'hFFFF, 16'hFFFF, "R10");

        // R7: same-cycle tie goes left; then release meets pending right
        cur_tag = "R7";
        sem_wr(0, 3'd6, 1'b0); sem_wr(1, 3'd6, 1'b0); tick();
        both_quiet(); tick();
        read_both(3'd6, 16'h0000, 16'hFFFF, "R7");
        cur_tag = "R6";
        sem_wr(0, 3'd6, 1'b1); sem_wr(1, 3'd6, 1'b0); tick();
        both_quiet(); tick();
        read_both(3'd6, 16'hFFFF, 16'h0000, "R6");

        // R2: write with sel_n high does nothing; ce_n low with no byte lane is a valid access
        cur_tag = "R2";
        drv(0, 1, 1, 0, 1, 1, 1, 3'd0, 1'b0); tick(); both_quiet(); tick();
        read_both(3'd0, 16'hFFFF, 16'hFFFF, "R2");
        cur_tag = "R2";
        drv(0, 0, 0, 0, 1, 1, 1, 3'd0, 1'b0); tick();
        drv(0, 0, 0, 1, 0, 1, 1, 3'd0, 1'b1); tick();
        check("R2", "direct l_rdat", l_rdat, 16'h0000);
        sem_wr(0, 3'd0, 1'b1); tick(); both_quiet(); tick();

        // R8: read held through a hand-over to the reader
        cur_tag = "R8";
        sem_wr(1, 3'd1, 1'b0); tick();
        quiet(1); sem_wr(0, 3'd1, 1'b0); tick();
        sem_rd(0, 3'd1); tick();
        check("R8", "capture l_rdat", l_rdat, 16'hFFFF);
        sem_wr(1, 3'd1, 1'b1); tick();
        quiet(1); tick();
        check("R8", "frozen l_rdat", l_rdat, 16'hFFFF);
        quiet(0); tick();
        check("R8", "idle l_rdat", l_rdat, 16'h0000);
        sem_rd(0, 3'd1); tick();
        check("R8", "fresh l_rdat", l_rdat, 16'h0000);
        sem_wr(0, 3'd1, 1'b1); tick(); both_quiet(); tick();

        // R9: illegal combination ignored, one-cycle error pulse
        cur_tag = "R9";
        drv(0, 0, 0, 0, 1, 0, 1, 3'd7, 1'b0);
        drv(1, 0, 0, 0, 1, 1, 0, 3'd7, 1'b0);
        tick();
        check("R9", "l_err pulse", {15'h0, l_err}, 16'h1);
        check("R9", "r_err pulse", {15'h0, r_err}, 16'h1);
        both_quiet(); tick();
        check("R9", "l_err cleared", {15'h0, l_err}, 16'h0);
        read_both(3'd7, 16'hFFFF, 16'hFFFF, "R9");

        // final sweep of all flags
        for (int i = 0; i < 8; i++) begin
            cur_tag = "R3";
            sem_rd(0, 3'(i)); sem_rd(1, 3'(i)); tick();
            both_quiet(); tick();
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule